// File: doc/BRIEF.md
# Microframe Interrupt Rate Limiter

This block sits between the event sources of a bus host controller and its single interrupt line. It keeps the line from toggling more often than software allows. Each cause has a sticky status bit, and software clears a bit by writing 1 to it. A threshold register picks the spacing between interrupts, counted in microframe ticks. The spacing is one of 1, 2, 4, 8, 16, 32 or 64 ticks. A threshold of zero turns the limiting off, and the line then follows pending enabled causes at once. Causes that arrive between boundaries wait in their status bits and raise the line at the next boundary.

The block also runs the handshake for the async-advance doorbell. Software rings the doorbell by writing a 1 into the configuration word. The schedule logic later pulses an eviction-done strobe. The block then sets the async-advance status bit and drops the doorbell one cycle later. That status bit then reaches the interrupt line through the same threshold gating as every other cause.

Top module: `uframe_irq_moderator`

## Requirements
- R1: While reset is held, and after its release, every status bit, the doorbell and the interrupt line read 0, and the threshold is 0.
- R2: With threshold 0, the line rises in the second cycle after the clock edge that samples an enabled event pulse.
- R3: With a one-hot threshold of 2^k, the line rises only at a boundary. The first boundary is the 2^k-th sampled tick after the last configuration write, and further boundaries follow every 2^k ticks.
- R4: A threshold that is not one-hot selects the interval of its highest set bit. Any set bit at position 6 or above selects 64 ticks.
- R5: Each configuration write restarts the tick count from zero. A tick sampled in the same cycle as the write is not counted.
- R6: An event pulse sets its status bit (bits 0 to NUM_EVT-1) at the next edge, and the bit stays set until it is cleared. When a set and a clear reach the same bit in one cycle, the set wins.
- R7: A status-clear write clears exactly the bits whose mask bits are 1. All other bits keep their value.
- R8: The line is never raised by a cause whose enable bit is 0. The line falls one cycle after the last pending enabled cause is cleared.
- R9: The doorbell rises only when a configuration write carries a 1 in its doorbell bit. A write with 0 in that bit has no effect on the doorbell.
- R10: An eviction-done strobe that arrives while the doorbell is set sets status bit NUM_EVT, and the doorbell falls in the following cycle. A strobe that arrives while the doorbell is clear is ignored.
- R11: When enabled, the async-advance status reaches the line at the next threshold boundary, in the same way as the other causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_thr | input | THR_W | Threshold value written by cfg_wr |
| cfg_bell | input | 1 | Doorbell bit written by cfg_wr (1 rings) |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_mask | input | NUM_EVT+1 | Bits to clear (1 clears) |
| uf_tick | input | 1 | One-cycle pulse per microframe |
| evt_pulse | input | NUM_EVT | Event pulses for ordinary causes |
| irq_en | input | NUM_EVT+1 | Per-cause enable, top bit for async advance |
| evict_done | input | 1 | Schedule logic has evicted cached state |
| sts | output | NUM_EVT+1 | Sticky status bits, top bit async advance |
| bell | output | 1 | Doorbell state |
| irq | output | 1 | Interrupt line |

## Verification
The bench counts the ticks until the line rises for each threshold code. An off-by-one in the interval counter would move the rise one tick early or late. A design that skipped the restart on a configuration write would rise two ticks early. It also writes threshold codes that are not one-hot, including 0x83. A design that decoded these from the lowest set bit, or ignored the high bits, would fire after the wrong number of ticks. Further cases cover a set and a clear on the same status bit in one cycle, a disabled cause that is enabled later, and eviction strobes that arrive with the doorbell clear. These would catch lost events, interrupts from disabled causes, and a doorbell that fell before its status bit was set.

// File: rtl/uframe_irq_pkg.sv
package uframe_irq_pkg;

   // Doorbell handshake states
   typedef enum logic [1:0] {
      BELL_IDLE   = 2'd0,
      BELL_ARMED  = 2'd1,
      BELL_RETIRE = 2'd2
   } bell_state_e;

endpackage

// File: rtl/uframe_thr_decode.sv
// Folds a raw threshold code onto a power-of-two interval and gives the
// terminal count of the tick counter for that interval.
module uframe_thr_decode #(
   parameter int THR_W   = 8,
   parameter int MAX_LOG = 6,
   parameter int CNT_W   = MAX_LOG
) (
   input  logic [THR_W-1:0] thr,
   output logic             immediate,
   output logic [CNT_W-1:0] wrap_at
);
   localparam int LOG_W = $clog2(MAX_LOG + 1);

   logic [MAX_LOG:0] folded;
   logic [LOG_W-1:0] sel;

   genvar gi;
   generate
      for (gi = 0; gi < MAX_LOG; gi++) begin : g_low
         assign folded[gi] = thr[gi];
      end
      if (THR_W == MAX_LOG + 1) begin : g_exact
         assign folded[MAX_LOG] = thr[MAX_LOG];
      end else begin : g_clamp
         assign folded[MAX_LOG] = |thr[THR_W-1:MAX_LOG];
      end
   endgenerate

   always_comb begin
      sel = '0;
      for (int i = 0; i <= MAX_LOG; i++) begin
         if (folded[i]) sel = LOG_W'(i);
      end
   end

   always_comb begin
      for (int j = 0; j < CNT_W; j++) begin
         wrap_at[j] = (j < int'(sel));
      end
   end

   assign immediate = ~|thr;

endmodule

// File: rtl/uframe_interval_timer.sv
// Counts microframe ticks and flags the boundary where held interrupts
// may be released.
module uframe_interval_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic             immediate,
   input  logic [CNT_W-1:0] wrap_at,
   output logic             boundary
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_wrap;

   assign at_wrap  = (cnt_q == wrap_at);
   assign boundary = immediate | (tick & ~restart & at_wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (tick && !immediate) begin
         cnt_q <= at_wrap ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/uframe_doorbell.sv
// Async-advance doorbell: armed by software, retired after the status bit
// has been set by an eviction strobe.
module uframe_doorbell
   import uframe_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ring,
   input  logic evict_done,
   output logic aa_set,
   output logic bell
);
   bell_state_e state_q, state_d;

   assign aa_set = (state_q == BELL_ARMED) & evict_done;
   assign bell   = (state_q != BELL_IDLE);

   always_comb begin
      state_d = state_q;
      case (state_q)
         BELL_IDLE:   if (ring) state_d = BELL_ARMED;
         BELL_ARMED:  if (evict_done) state_d = BELL_RETIRE;
         BELL_RETIRE: state_d = ring ? BELL_ARMED : BELL_IDLE;
         default:     state_d = BELL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= BELL_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/uframe_status_bank.sv
// Sticky status bits, set by hardware, cleared by writing 1.
module uframe_status_bank #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic         clr_wr,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] sts
);
   genvar gb;
   generate
      for (gb = 0; gb < W; gb++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       bit_q <= 1'b0;
            else if (set[gb])                 bit_q <= 1'b1;
            else if (clr_wr && clr_mask[gb])  bit_q <= 1'b0;
         end
         assign sts[gb] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/uframe_irq_moderator.sv
module uframe_irq_moderator #(
   parameter  int NUM_EVT = 4,
   parameter  int THR_W   = 8,
   parameter  int MAX_LOG = 6,
   localparam int STS_W   = NUM_EVT + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [THR_W-1:0]   cfg_thr,
   input  logic               cfg_bell,
   input  logic               sts_clr_wr,
   input  logic [STS_W-1:0]   sts_clr_mask,
   input  logic               uf_tick,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic [STS_W-1:0]   irq_en,
   input  logic               evict_done,
   output logic [STS_W-1:0]   sts,
   output logic               bell,
   output logic               irq
);
   localparam int CNT_W = MAX_LOG;

   generate
      if (NUM_EVT < 1) begin : g_bad_evt
         $error("NUM_EVT must be at least 1");
      end
      if (MAX_LOG < 1 || THR_W < MAX_LOG + 1) begin : g_bad_thr
         $error("THR_W must cover MAX_LOG and MAX_LOG must be at least 1");
      end
   endgenerate

   logic [THR_W-1:0] thr_q;
   logic             immediate;
   logic [CNT_W-1:0] wrap_at;
   logic             bnd;
   logic             aa_set;
   logic [STS_W-1:0] set_vec;
   logic             pend_any;
   logic             irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      thr_q <= '0;
      else if (cfg_wr) thr_q <= cfg_thr;
   end

   uframe_thr_decode #(
      .THR_W(THR_W), .MAX_LOG(MAX_LOG), .CNT_W(CNT_W)
   ) u_dec (
      .thr(thr_q), .immediate(immediate), .wrap_at(wrap_at)
   );

   uframe_interval_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .tick(uf_tick),
      .immediate(immediate), .wrap_at(wrap_at), .boundary(bnd)
   );

   uframe_doorbell u_bell (
      .clk(clk), .rst_n(rst_n), .ring(cfg_wr & cfg_bell),
      .evict_done(evict_done), .aa_set(aa_set), .bell(bell)
   );

   assign set_vec = {aa_set, evt_pulse};

   uframe_status_bank #(.W(STS_W)) u_sts (
      .clk(clk), .rst_n(rst_n), .set(set_vec), .clr_wr(sts_clr_wr),
      .clr_mask(sts_clr_mask), .sts(sts)
   );

   // Line rises at a boundary, holds while anything enabled is pending.
   assign pend_any = |(sts & irq_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= pend_any & (irq_q | bnd);
   end

   assign irq = irq_q;

endmodule

// File: rtl/uframe_irq_moderator_chk.sv
module uframe_irq_moderator_chk #(
   parameter int NUM_EVT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_wr,
   input logic               cfg_bell,
   input logic [NUM_EVT-1:0] evt_pulse,
   input logic [NUM_EVT:0]   irq_en,
   input logic               evict_done,
   input logic [NUM_EVT:0]   sts,
   input logic               bell,
   input logic               irq,
   input logic               boundary
);
   // R1
   a_r1_reset_quiet: assert property (@(negedge clk)
      !rst_n |-> (sts == '0 && !bell && !irq));

   a_r3_rise_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(boundary));

   a_r8_irq_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(|(sts & irq_en)));

   a_r6_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
      |evt_pulse |=> ((sts[NUM_EVT-1:0] & $past(evt_pulse)) == $past(evt_pulse)));

   a_r9_bell_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bell) |-> $past(cfg_wr && cfg_bell));

   a_r10_bell_after_status: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bell) |-> $past(sts[NUM_EVT]));

   a_r10_status_needs_bell: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[NUM_EVT]) |-> $past(bell && evict_done));

endmodule

bind uframe_irq_moderator uframe_irq_moderator_chk #(.NUM_EVT(NUM_EVT)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_bell(cfg_bell),
   .evt_pulse(evt_pulse), .irq_en(irq_en), .evict_done(evict_done),
   .sts(sts), .bell(bell), .irq(irq), .boundary(bnd)
);

// File: tb/uframe_irq_moderator_tb_top.sv
module uframe_irq_moderator_tb_top;
   localparam int NE   = 4;
   localparam int SW   = NE + 1;
   localparam int TW   = 8;
   localparam int MLOG = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          cfg_wr = 1'b0;
   logic [TW-1:0] cfg_thr = '0;
   logic          cfg_bell = 1'b0;
   logic          sts_clr_wr = 1'b0;
   logic [SW-1:0] sts_clr_mask = '0;
   logic          uf_tick = 1'b0;
   logic [NE-1:0] evt_pulse = '0;
   logic [SW-1:0] irq_en = '0;
   logic          evict_done = 1'b0;
   logic [SW-1:0] sts;
   logic          bell;
   logic          irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit running = 0;

   always #2 clk = ~clk;

   uframe_irq_moderator #(.NUM_EVT(NE), .THR_W(TW), .MAX_LOG(MLOG)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_thr(cfg_thr),
      .cfg_bell(cfg_bell), .sts_clr_wr(sts_clr_wr), .sts_clr_mask(sts_clr_mask),
      .uf_tick(uf_tick), .evt_pulse(evt_pulse), .irq_en(irq_en),
      .evict_done(evict_done), .sts(sts), .bell(bell), .irq(irq)
   );

   // ---------------- reference model ----------------
   logic [TW-1:0] m_thr = '0;
   int            m_cnt = 0;
   logic [SW-1:0] m_sts = '0;
   int            m_bell = 0;
   bit            m_irq = 0;
   int            m_lg;
   bit            m_bnd;
   bit            m_aa;

   function automatic int eff_log(input logic [TW-1:0] t);
      for (int k = TW - 1; k >= 0; k--) begin
         if (t[k]) return (k > MLOG) ? MLOG : k;
      end
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_thr = '0; m_cnt = 0; m_sts = '0; m_bell = 0; m_irq = 0;
      end else begin
         m_lg = eff_log(m_thr);
         if (m_lg < 0)    m_bnd = 1;
         else if (cfg_wr) m_bnd = 0;
         else             m_bnd = uf_tick && (m_cnt == (1 << m_lg) - 1);
         m_irq = ((m_sts & irq_en) != '0) && (m_irq || m_bnd);
         if (cfg_wr) m_cnt = 0;
         else if (uf_tick && m_lg >= 0) m_cnt = m_bnd ? 0 : m_cnt + 1;
         m_aa = (m_bell == 1) && evict_done;
         if (m_aa)                     m_bell = 2;
         else if (cfg_wr && cfg_bell)  m_bell = 1;
         else if (m_bell == 2)         m_bell = 0;
         if (sts_clr_wr) m_sts = m_sts & ~sts_clr_mask;
         m_sts = m_sts | {m_aa, evt_pulse};
         if (cfg_wr) m_thr = cfg_thr;
      end
   end

   task automatic cmp_model(input string req);
      checks++;
      if (sts !== m_sts || bell !== (m_bell != 0) || irq !== m_irq) begin
         errors++;
         $display("FAIL %s: sts=%b bell=%b irq=%b expected sts=%b bell=%b irq=%b",
                  req, sts, bell, irq, m_sts, (m_bell != 0), m_irq);
      end
   endtask

   task automatic expect_int(input int got, input int exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && running) cmp_model("R2 R3 R8 R6 R10 cycle compare");
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cfg(input logic [TW-1:0] t, input logic b);
      @(negedge clk); cfg_wr = 1; cfg_thr = t; cfg_bell = b;
      @(negedge clk); cfg_wr = 0; cfg_bell = 0;
   endtask

   task automatic event_on(input logic [NE-1:0] m);
      @(negedge clk); evt_pulse = m;
      @(negedge clk); evt_pulse = '0;
   endtask

   task automatic clear_all();
      @(negedge clk); sts_clr_wr = 1; sts_clr_mask = '1;
      @(negedge clk); sts_clr_wr = 0; sts_clr_mask = '0;
      idle(2);
   endtask

   task automatic give_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); uf_tick = 1;
         @(negedge clk); uf_tick = 0;
      end
   endtask

   task automatic ticks_to_irq(input int limit, output int n);
      n = 0;
      for (int i = 1; i <= limit; i++) begin
         @(negedge clk); uf_tick = 1;
         @(negedge clk); uf_tick = 0;
         if (irq) begin n = i; break; end
      end
   endtask

   int n;

   initial begin
      #1 rst_n = 1'b0;
      idle(3);
      expect_int(int'(sts), 0, "R1 status in reset");
      expect_int(int'(irq), 0, "R1 irq in reset");
      @(negedge clk); rst_n = 1'b1; running = 1;
      idle(1);
      expect_int(int'({sts, bell, irq}), 0, "R1 after release");

      // R2 immediate delivery
      irq_en = '1;
      event_on(4'b0001);
      expect_int(int'(sts[0]), 1, "R6 status set");
      expect_int(int'(irq), 0, "R2 not yet");
      idle(1);
      expect_int(int'(irq), 1, "R2 immediate rise");

      // R8 fall after clear, R7
      @(negedge clk); sts_clr_wr = 1; sts_clr_mask = 5'b00001;
      @(negedge clk); sts_clr_wr = 0; sts_clr_mask = '0;
      expect_int(int'(sts), 0, "R7 cleared");
      expect_int(int'(irq), 1, "R8 still high one cycle");
      idle(1);
      expect_int(int'(irq), 0, "R8 fall");

      // R3 one-hot threshold 4, two consecutive intervals
      cfg(8'h04, 0);
      event_on(4'b0010);
      expect_int(int'(irq), 0, "R3 held off");
      ticks_to_irq(10, n);
      expect_int(n, 4, "R3 first boundary");
      clear_all();
      event_on(4'b0010);
      ticks_to_irq(10, n);
      expect_int(n, 4, "R3 periodic boundary");
      clear_all();

      // R5 restart on write
      cfg(8'h04, 0);
      event_on(4'b0100);
      give_ticks(2);
      expect_int(int'(irq), 0, "R5 before rewrite");
      cfg(8'h04, 0);
      ticks_to_irq(10, n);
      expect_int(n, 4, "R5 restart");
      clear_all();

      // R4 folding of non one-hot codes
      cfg(8'h06, 0);
      event_on(4'b0001);
      ticks_to_irq(20, n);
      expect_int(n, 4, "R4 code 0x06");
      clear_all();
      cfg(8'h83, 0);
      event_on(4'b0001);
      ticks_to_irq(80, n);
      expect_int(n, 64, "R4 code 0x83");
      clear_all();
      cfg(8'h03, 0);
      event_on(4'b0001);
      ticks_to_irq(10, n);
      expect_int(n, 2, "R4 code 0x03");
      clear_all();

      // R6 set beats clear
      @(negedge clk); evt_pulse = 4'b1000; sts_clr_wr = 1; sts_clr_mask = 5'b01000;
      @(negedge clk); evt_pulse = '0; sts_clr_wr = 0; sts_clr_mask = '0;
      expect_int(int'(sts[3]), 1, "R6 set wins");
      clear_all();

      // R7 selective clear
      event_on(4'b0011);
      @(negedge clk); sts_clr_wr = 1; sts_clr_mask = 5'b00001;
      @(negedge clk); sts_clr_wr = 0; sts_clr_mask = '0;
      expect_int(int'(sts[1:0]), 2, "R7 other bit kept");
      clear_all();

      // R8 disabled cause
      irq_en = 5'b00001;
      event_on(4'b0100);
      ticks_to_irq(6, n);
      expect_int(n, 0, "R8 disabled cause silent");
      expect_int(int'(sts[2]), 1, "R6 latched while disabled");
      irq_en = 5'b00101;
      ticks_to_irq(6, n);
      expect_int(n, 2, "R8 enabled later");
      clear_all();

      // R9 and R10 doorbell
      cfg(8'h00, 1);
      expect_int(int'(bell), 1, "R9 ring");
      cfg(8'h00, 0);
      expect_int(int'(bell), 1, "R9 write of 0 ignored");
      @(negedge clk); evict_done = 1;
      @(negedge clk); evict_done = 0;
      expect_int(int'(sts[NE]), 1, "R10 status set");
      expect_int(int'(bell), 1, "R10 bell held one cycle");
      idle(1);
      expect_int(int'(bell), 0, "R10 bell retired");
      clear_all();
      @(negedge clk); evict_done = 1;
      @(negedge clk); evict_done = 0;
      expect_int(int'(sts[NE]), 0, "R10 strobe without bell ignored");

      // R11 async advance through threshold 8
      irq_en = '1;
      cfg(8'h08, 1);
      @(negedge clk); evict_done = 1;
      @(negedge clk); evict_done = 0;
      expect_int(int'(irq), 0, "R11 held");
      ticks_to_irq(12, n);
      expect_int(n, 8, "R11 boundary");
      clear_all();

      running = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule